// File: doc/BRIEF.md
# Power-Rail Enable and Wakeup Sequencer

This block drives a single power-enable line towards an external power-management device. Once control of that line is armed in a 32-bit configuration word, a strobe from the second calendar alarm turns the rail OFF. The rail comes back ON when an enabled external wakeup pin reaches its programmed active level, or when a strobe from the first alarm arrives.

Each of the four wakeup pins has its own enable bit and polarity bit in the configuration word. A pin's level is passed through a two-flop synchroniser before its polarity is checked. While control is not armed, the rail is held ON whatever the alarms or pins do.

The configuration word is accepted only as a whole: a write that does not assert all four byte strobes is dropped. The alarm events arrive as one-cycle input strobes. Pin debounce, the calendar and the alarm comparators are outside this block.

Top module: `pmic_pwr_wake`

## Requirements
- R1: After reset `pwrEnOut` is 1 (ON), and `cfgRdData` reads 0, so every wakeup enable is 0 and control is not armed.
- R2: A write with `cfgWrEn`=1 and `cfgWrStrb`=4'b1111 loads the configuration at that clock edge. Bit 16 arms control, bits 3:0 enable wakeup pins 3:0, and bits 7:4 set the polarity of pins 3:0. `cfgRdData` returns these bits, and every other bit reads 0.
- R3: A write whose `cfgWrStrb` is anything other than 4'b1111 leaves the configuration unchanged.
- R4: While bit 16 is 0, `pwrEnOut` stays 1 whatever `alarm1Evt`, `alarm2Evt` and `wakeIn` do.
- R5: With bit 16 set and the output ON, an `alarm2Evt` strobe makes `pwrEnOut` 0 at that clock edge. The output never falls without that strobe.
- R6: While the output is OFF, an enabled wakeup pin at its active level returns `pwrEnOut` to 1. A polarity bit of 1 makes the pin active low, and a polarity bit of 0 makes it active high.
- R7: A wakeup pin whose enable bit is 0 has no effect on `pwrEnOut`, at either level.
- R8: While the output is OFF, an `alarm1Evt` strobe returns `pwrEnOut` to 1 at that clock edge.
- R9: A pin level that is driven just after an edge is seen by the output at the third following edge. `pwrEnOut` is unchanged after two edges and switches at the third.
- R10: Clearing bit 16 while the output is OFF returns `pwrEnOut` to 1 at the edge after the write's edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgWrEn | input | 1 | Configuration write request |
| cfgWrStrb | input | 4 | Byte strobes of the write |
| cfgWrData | input | 32 | Write data |
| cfgRdData | output | 32 | Current configuration word |
| alarm1Evt | input | 1 | First alarm strobe, which wakes the rail |
| alarm2Evt | input | 1 | Second alarm strobe, which turns the rail off |
| wakeIn | input | 4 | Asynchronous external wakeup pins |
| pwrEnOut | output | 1 | Power-enable line, where 1 means ON |

## Verification
The bench sweeps every pin through every combination of enable, polarity and applied level. A swapped polarity sense, or a pin that acts while disabled, therefore shows up as a wrong final rail state. Within each sweep step the output is sampled two and three edges after the pin changes. A synchroniser with too few stages, or with too many, makes the rail switch early or late. The bench also issues writes with partial byte strobes, which a design that merges bytes would accept. It drives alarms while control is disarmed, and disarms control while the rail is OFF. A design that ignores the arm bit would let the rail drop in the first case and keep it low in the second.

// File: rtl/pmic_wake_pkg.sv
package pmic_wake_pkg;
  localparam int unsigned CFG_W      = 32;
  localparam int unsigned STRB_W     = CFG_W / 8;
  localparam int unsigned ARM_BIT    = 16;

  typedef struct packed {
    logic cfgLoad;   // whole-word write accepted this cycle
  } ctlStrobes_t;
endpackage

// File: rtl/pmic_wake_dp.sv
module pmic_wake_dp
  import pmic_wake_pkg::*;
#(
  parameter int unsigned NUM_WAKE    = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctlStrobes_t         strobes,
  input  logic                cfgWrEn,
  input  logic [STRB_W-1:0]   cfgWrStrb,
  input  logic [CFG_W-1:0]    cfgWrData,
  input  logic [NUM_WAKE-1:0] wakeIn,
  output logic [CFG_W-1:0]    cfgRdData,
  output logic                ctlArmed,
  output logic                wakeHit
);
  localparam int unsigned POL_LSB = NUM_WAKE;

  logic [NUM_WAKE-1:0] wakeEnQ;
  logic [NUM_WAKE-1:0] wakePolQ;
  logic                armQ;
  logic [NUM_WAKE-1:0] pinSync;
  logic [NUM_WAKE-1:0] pinActive;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wakeEnQ  <= '0;
      wakePolQ <= '0;
      armQ     <= 1'b0;
    end else if (strobes.cfgLoad) begin
      wakeEnQ  <= cfgWrData[NUM_WAKE-1:0];
      wakePolQ <= cfgWrData[POL_LSB +: NUM_WAKE];
      armQ     <= cfgWrData[ARM_BIT];
    end
  end

  for (genvar p = 0; p < NUM_WAKE; p++) begin : g_pin
    logic [SYNC_STAGES-1:0] shQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) shQ <= '0;
      else       shQ <= {shQ[SYNC_STAGES-2:0], wakeIn[p]};
    end
    assign pinSync[p]   = shQ[SYNC_STAGES-1];
    // polarity 1 = active low, 0 = active high
    assign pinActive[p] = wakeEnQ[p] & (pinSync[p] ^ wakePolQ[p]);
  end

  assign wakeHit  = |pinActive;
  assign ctlArmed = armQ;

  always_comb begin
    cfgRdData                       = '0;
    cfgRdData[NUM_WAKE-1:0]         = wakeEnQ;
    cfgRdData[POL_LSB +: NUM_WAKE]  = wakePolQ;
    cfgRdData[ARM_BIT]              = armQ;
  end

  AST_PARTIAL_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrEn && cfgWrStrb != '1) |=> $stable(cfgRdData)); // R3
  AST_DISABLED_NO_HIT: assert property (@(posedge clk) disable iff (!rstN)
    (cfgRdData[NUM_WAKE-1:0] == '0) |-> !wakeHit); // R7
endmodule

// File: rtl/pmic_pwr_ctrl.sv
module pmic_pwr_ctrl
  import pmic_wake_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [STRB_W-1:0] cfgWrStrb,
  input  logic              alarm1Evt,
  input  logic              alarm2Evt,
  input  logic              ctlArmed,
  input  logic              wakeHit,
  output ctlStrobes_t       strobes,
  output logic              pwrEnOut
);
  logic pwrOnQ;
  logic pwrOnD;

  always_comb begin
    strobes         = '0;
    strobes.cfgLoad = cfgWrEn && (cfgWrStrb == '1);
  end

  always_comb begin
    if (!ctlArmed)   pwrOnD = 1'b1;
    else if (pwrOnQ) pwrOnD = !alarm2Evt;
    else             pwrOnD = wakeHit || alarm1Evt;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pwrOnQ <= 1'b1;
    else       pwrOnQ <= pwrOnD;
  end

  assign pwrEnOut = pwrOnQ;

  AST_DISARMED_ON: assert property (@(posedge clk) disable iff (!rstN)
    !ctlArmed |=> pwrEnOut); // R4
  AST_ALARM2_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (pwrEnOut && ctlArmed && alarm2Evt) |=> !pwrEnOut); // R5
  AST_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(pwrEnOut) |-> $past(alarm2Evt)); // R5
  AST_WAKE_ON: assert property (@(posedge clk) disable iff (!rstN)
    (!pwrEnOut && wakeHit) |=> pwrEnOut); // R6
  AST_ALARM1_ON: assert property (@(posedge clk) disable iff (!rstN)
    (!pwrEnOut && alarm1Evt) |=> pwrEnOut); // R8
endmodule

// File: rtl/pmic_pwr_wake.sv
module pmic_pwr_wake
  import pmic_wake_pkg::*;
#(
  parameter int unsigned NUM_WAKE    = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cfgWrEn,
  input  logic [STRB_W-1:0]   cfgWrStrb,
  input  logic [CFG_W-1:0]    cfgWrData,
  output logic [CFG_W-1:0]    cfgRdData,
  input  logic                alarm1Evt,
  input  logic                alarm2Evt,
  input  logic [NUM_WAKE-1:0] wakeIn,
  output logic                pwrEnOut
);
  ctlStrobes_t strobes;
  logic        ctlArmed;
  logic        wakeHit;

  pmic_wake_dp #(.NUM_WAKE(NUM_WAKE), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .cfgWrEn(cfgWrEn), .cfgWrStrb(cfgWrStrb), .cfgWrData(cfgWrData),
    .wakeIn(wakeIn), .cfgRdData(cfgRdData),
    .ctlArmed(ctlArmed), .wakeHit(wakeHit)
  );

  pmic_pwr_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrStrb(cfgWrStrb),
    .alarm1Evt(alarm1Evt), .alarm2Evt(alarm2Evt),
    .ctlArmed(ctlArmed), .wakeHit(wakeHit),
    .strobes(strobes), .pwrEnOut(pwrEnOut)
  );
endmodule

// File: tb/pmic_pwr_wake_tb.sv
module pmic_pwr_wake_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [3:0]  cfgWrStrb = '0;
  logic [31:0] cfgWrData = '0;
  logic [31:0] cfgRdData;
  logic        alarm1Evt = 1'b0;
  logic        alarm2Evt = 1'b0;
  logic [3:0]  wakeIn = '0;
  logic        pwrEnOut;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  localparam logic [31:0] CFG_MASK = 32'h0001_00FF;

  always #5 clk = ~clk;

  pmic_pwr_wake u_dut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrStrb(cfgWrStrb),
    .cfgWrData(cfgWrData), .cfgRdData(cfgRdData), .alarm1Evt(alarm1Evt),
    .alarm2Evt(alarm2Evt), .wakeIn(wakeIn), .pwrEnOut(pwrEnOut)
  );

  task automatic tick(input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d, input logic [3:0] s);
    cfgWrEn = 1'b1; cfgWrStrb = s; cfgWrData = d;
    tick(1);
    cfgWrEn = 1'b0; cfgWrStrb = '0;
  endtask

  task automatic pulseA2();
    alarm2Evt = 1'b1; tick(1); alarm2Evt = 1'b0;
  endtask

  task automatic pulseA1();
    alarm1Evt = 1'b1; tick(1); alarm1Evt = 1'b0;
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    logic [31:0] cfg;
    logic        act;
    logic        hit;
    @(negedge clk);
    tick(2);
    rstN = 1'b1;
    tick(1);
    // R1 reset state
    chk("R1", {31'b0, pwrEnOut}, 32'd1);
    chk("R1", cfgRdData, 32'h0);

    // R2 full write readback, reserved bits read 0
    wr(32'hFFFF_FFFF, 4'hF);
    chk("R2", cfgRdData, CFG_MASK);
    wr(32'h0001_00A5, 4'hF);
    chk("R2", cfgRdData, 32'h0001_00A5);

    // R3 partial strobes dropped
    for (int s = 0; s < 15; s++) begin
      wr(32'h0000_005A, s[3:0]);
      chk("R3", cfgRdData, 32'h0001_00A5);
    end

    // R4 disarmed: alarms and pins have no effect
    wr(32'h0000_000F, 4'hF);
    wakeIn = 4'h0;
    tick(3);
    pulseA2();
    chk("R4", {31'b0, pwrEnOut}, 32'd1);
    wakeIn = 4'hF; pulseA2(); pulseA1();
    tick(3);
    chk("R4", {31'b0, pwrEnOut}, 32'd1);

    // R10 disarm while OFF
    wakeIn = 4'h0;
    wr(32'h0001_0000, 4'hF);
    pulseA2();
    chk("R5", {31'b0, pwrEnOut}, 32'd0);
    wr(32'h0000_0000, 4'hF);
    chk("R10", {31'b0, pwrEnOut}, 32'd0);
    tick(1);
    chk("R10", {31'b0, pwrEnOut}, 32'd1);

    // Sweep: pin x enable x polarity x level (R5..R9)
    for (int p = 0; p < 4; p++) begin
      for (int en = 0; en < 2; en++) begin
        for (int pol = 0; pol < 2; pol++) begin
          for (int lvl = 0; lvl < 2; lvl++) begin
            cfg = 32'h0001_0000;
            cfg[p]     = en[0];
            cfg[4 + p] = pol[0];
            // other pins disabled, driven with a changing pattern (R7)
            wakeIn = 4'(p * 5 + lvl * 3 + pol);
            wakeIn[p] = pol[0];   // inactive level of pin p
            wr(cfg, 4'hF);
            tick(3);
            chk("R6", {31'b0, pwrEnOut}, 32'd1);
            pulseA2();
            chk("R5", {31'b0, pwrEnOut}, 32'd0);
            wakeIn[p] = lvl[0];
            wakeIn = wakeIn ^ (4'hF & ~(4'b1 << p));
            hit = en[0] & (lvl[0] ^ pol[0]);
            tick(2);
            chk("R9", {31'b0, pwrEnOut}, 32'd0);
            tick(1);
            act = pwrEnOut;
            if (en == 0) chk("R7", {31'b0, act}, 32'd0);
            else         chk("R6", {31'b0, act}, {31'b0, hit});
            tick(2);
            chk("R9", {31'b0, pwrEnOut}, {31'b0, hit});
            if (!hit) begin
              pulseA1();
              chk("R8", {31'b0, pwrEnOut}, 32'd1);
            end
          end
        end
      end
    end
    finishRun();
  end
endmodule